// File: doc/BRIEF.md
# I2S Sample Capture Buffer

This block receives a standard I2S stereo stream and deposits each sample into a small on-chip buffer of 16 left/right pairs. Software reaches the buffer and a few control registers through a simple single-cycle memory-mapped slave port. A build parameter chooses the clock role. In the clock-master role the block generates SCK from the bus clock using a programmable divider, and generates WS as well. In the clock-slave role it takes SCK and WS from outside, brings them into the bus clock domain and detects their edges there.

The capture length (bits kept per sample) is programmed at run time and does not need to match the sender's word length. A shorter sender word is padded with zeros at the bottom. A longer sender word is cut down to its leading bits. The buffer is filled as a ring in two halves. Each half raises its own sticky status flag, so software can drain one half while the other half is being refilled. A maskable interrupt combines the flags.

Top module: `i2s_rx_buf`

## Requirements
- R1: After reset, the config, mask and status registers read 0, irq_o is low, and the generated sck_o/ws_o are low.
- R2: The word at offset 0 reads 0x1B1 in a clock-master build and 0x191 in a clock-slave build.
- R3: Offset 1 (config) and offset 2 (mask, bits 1:0) read back what was last written. Config bit 0 enables capture, bits 15:8 hold the SCK divider and bits 23:16 hold the capture length in bits.
- R4: Status (offset 3) bit 0 becomes 1 once pairs 0 to 7 of the ring have been written, and only while capture is enabled.
- R5: Status bit 1 becomes 1 once pairs 8 to 15 have been written, after which filling continues at pair 0.
- R6: Writing status with a 1 in a bit position clears that bit. Bits written with 0 are kept.
- R7: irq_o is high exactly when some status bit and the same mask bit are both 1.
- R8: SD is sampled on rising SCK, MSB first, starting one SCK period after a WS change. WS low marks left. Pair k goes to offset 0x20+2k (left) and 0x21+2k (right), with consecutive pairs in arrival order and each value right-aligned.
- R9: When the sender word is shorter than the capture length, the missing low bits are 0 (a 20-bit word captured at 24 bits reads as the word shifted left by 4).
- R10: When the sender word is longer than the capture length, only its leading bits are kept (a 24-bit word captured at 16 bits reads as its upper 16 bits).
- R11: After enable, the first left/right pair whose left word began after the enable lands at pair 0. Words already in flight and a leading lone right word are dropped.
- R12: In a master build, SCK is high and low for divider+1 bus clocks each, and WS toggles on a falling SCK every 32 SCK periods. A slave build holds sck_o and ws_o low.
- R13: When a half-complete event and a clearing write to the same status bit fall in one cycle, the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | AW | Word offset |
| dat_i | input | DW | Write data |
| ack_o | output | 1 | Same-cycle acknowledge |
| dat_o | output | DW | Read data, combinational from adr_i |
| irq_o | output | 1 | Half-buffer interrupt |
| sck_i | input | 1 | Serial clock in (slave build) |
| ws_i | input | 1 | Word select in (slave build) |
| sd_i | input | 1 | Serial data |
| sck_o | output | 1 | Generated serial clock (master build) |
| ws_o | output | 1 | Generated word select (master build) |

## Verification
The set of a half-complete flag by the capture path and the write-one-to-clear from the bus can fall in the same clock. To make this happen, the bench keeps a clearing write to status bit 1 asserted on every cycle while the upper half fills, with only bit 1 unmasked. The bench judges the result by whether irq_o rises at least once during that stretch: if clearing took precedence, the bit could never become visible. The bench also confirms that the bit reads 0 once the writes stop.

// File: rtl/i2s_rx_buf.sv
module i2s_rx_buf #(
  parameter bit MASTER = 1'b0,
  parameter int DW     = 32,
  parameter int AW     = 6,
  parameter int PAIRS  = 16,
  parameter int SLOT   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic          ack_o,
  output logic [DW-1:0] dat_o,
  output logic          irq_o,
  input  logic          sck_i,
  input  logic          ws_i,
  input  logic          sd_i,
  output logic          sck_o,
  output logic          ws_o
);
  localparam int WORDS = 2 * PAIRS;
  localparam int PW    = $clog2(PAIRS);
  localparam int SW    = $clog2(SLOT);
  localparam logic [DW-1:0] VERSION = MASTER ? DW'('h1B1) : DW'('h191);

  logic [DW-1:0] cfg;
  logic [1:0]    mask, stat, set;
  logic          cfg_en;
  logic [7:0]    cfg_div, cfg_len;
  logic          wr;

  assign cfg_en  = cfg[0];
  assign cfg_div = cfg[15:8];
  assign cfg_len = cfg[23:16];
  assign wr      = cyc_i & stb_i & we_i;
  assign ack_o   = cyc_i & stb_i;
  assign irq_o   = |(stat & mask);

  // clock generation for the master build
  logic [7:0]    m_cnt;
  logic [SW-1:0] m_fall;
  logic          m_sck, m_ws;

  always_ff @(posedge clk) begin
    if (rst || !cfg_en) begin
      m_cnt  <= '0;
      m_fall <= '0;
      m_sck  <= 1'b0;
      m_ws   <= 1'b0;
    end else if (m_cnt == cfg_div) begin
      m_cnt <= '0;
      m_sck <= ~m_sck;
      if (m_sck) begin
        m_fall <= m_fall + 1'b1;
        if (m_fall == SW'(SLOT - 1)) m_ws <= ~m_ws;
      end
    end else begin
      m_cnt <= m_cnt + 8'd1;
    end
  end

  // two-stage synchroniser for the slave build
  logic [2:0] s1, s2;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {sck_i, ws_i, sd_i};
      s2 <= s1;
    end
  end

  logic sck_s, ws_s, sd_s;
  assign sck_s = MASTER ? m_sck : s2[2];
  assign ws_s  = MASTER ? m_ws  : s2[1];
  assign sd_s  = MASTER ? sd_i  : s2[0];
  assign sck_o = MASTER ? m_sck : 1'b0;
  assign ws_o  = MASTER ? m_ws  : 1'b0;

  // deserialiser and ring pointer
  logic          sck_d, ws_q, wvalid, got_left;
  logic [7:0]    bitn;
  logic [DW-1:0] sr;
  logic [PW-1:0] ptr;
  logic          rise, ws_chg, commit, wr_l, wr_r;

  assign rise   = sck_s & ~sck_d;
  assign ws_chg = rise & (ws_s ^ ws_q);
  assign commit = ws_chg & wvalid & cfg_en;
  assign wr_l   = commit & ~ws_q;
  assign wr_r   = commit & ws_q & got_left;
  assign set    = {wr_r & (ptr == PW'(PAIRS - 1)), wr_r & (ptr == PW'(PAIRS / 2 - 1))};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      ws_q     <= 1'b0;
      wvalid   <= 1'b0;
      got_left <= 1'b0;
      bitn     <= '0;
      sr       <= '0;
      ptr      <= '0;
    end else begin
      sck_d <= sck_s;
      if (!cfg_en) begin
        wvalid   <= 1'b0;
        got_left <= 1'b0;
        ptr      <= '0;
        ws_q     <= ws_s;
      end
      if (ws_chg) begin
        ws_q   <= ws_s;
        bitn   <= '0;
        sr     <= '0;
        wvalid <= cfg_en;
      end else if (rise && bitn < cfg_len && int'(bitn) < DW) begin
        sr   <= {sr[DW-2:0], sd_s};
        bitn <= bitn + 8'd1;
      end
      if (wr_l) got_left <= 1'b1;
      if (wr_r) begin
        got_left <= 1'b0;
        ptr      <= ptr + 1'b1;
      end
    end
  end

  logic [DW-1:0] mem [WORDS];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (wr_l) mem[{ptr, 1'b0}] <= sr;
      if (wr_r) mem[{ptr, 1'b1}] <= sr;
    end
  end

  // registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      mask <= '0;
      stat <= '0;
    end else begin
      if (wr && adr_i == AW'(1)) cfg  <= dat_i;
      if (wr && adr_i == AW'(2)) mask <= dat_i[1:0];
      stat <= (stat & ~((wr && adr_i == AW'(3)) ? dat_i[1:0] : 2'b00)) | set;
    end
  end

  always_comb begin
    dat_o = '0;
    if (adr_i[AW-1:PW+1] == (AW-PW-1)'(1)) begin
      dat_o = mem[adr_i[PW:0]];
    end else begin
      case (adr_i)
        AW'(0):  dat_o = VERSION;
        AW'(1):  dat_o = cfg;
        AW'(2):  dat_o = {{(DW-2){1'b0}}, mask};
        AW'(3):  dat_o = {{(DW-2){1'b0}}, stat};
        default: dat_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2s_rx_buf_chk.sv
module i2s_rx_buf_chk #(
  parameter bit MASTER = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       wr_st,
  input logic [1:0] wdat,
  input logic [1:0] st,
  input logic [1:0] mk,
  input logic       irq,
  input logic       sck,
  input logic       ws
);
  // R4
  st_set_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(st[0]) || $rose(st[1])) |-> $past(en));

  // R6
  st0_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st[0]) |-> $past(wr_st && wdat[0]));

  // R6
  st1_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st[1]) |-> $past(wr_st && wdat[1]));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (st != $past(st) || mk != $past(mk)));

  // R12
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (MASTER && $past(en) && !$stable(ws)) |-> $fell(sck));

  // R12
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !MASTER |-> (!sck && !ws));
endmodule

bind i2s_rx_buf i2s_rx_buf_chk #(.MASTER(MASTER)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (cfg_en),
  .wr_st (cyc_i && stb_i && we_i && (adr_i == AW'(3))),
  .wdat  (dat_i[1:0]),
  .st    (stat),
  .mk    (mask),
  .irq   (irq_o),
  .sck   (sck_o),
  .ws    (ws_o)
);

// File: tb/test_i2s_rx_buf.sv
module test_i2s_rx_buf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cyc_s = 0, cyc_m = 0, stb = 0, we = 0;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic        ack_s, ack_m, irq_s, irq_m;
  logic [31:0] dat_s, dat_m;
  logic        sck_os, ws_os, sck_om, ws_om;
  logic        tb_sck = 0, tb_ws = 0, sd_line = 0;

  i2s_rx_buf #(.MASTER(1'b0)) i_i2s_rx_buf (
    .clk(clk), .rst(rst), .cyc_i(cyc_s), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .ack_o(ack_s), .dat_o(dat_s), .irq_o(irq_s),
    .sck_i(tb_sck), .ws_i(tb_ws), .sd_i(sd_line), .sck_o(sck_os), .ws_o(ws_os));

  i2s_rx_buf #(.MASTER(1'b1)) i_i2s_rx_buf_mst (
    .clk(clk), .rst(rst), .cyc_i(cyc_m), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .ack_o(ack_m), .dat_o(dat_m), .irq_o(irq_m),
    .sck_i(1'b0), .ws_i(1'b0), .sd_i(sd_line), .sck_o(sck_om), .ws_o(ws_om));

  int vectors = 0, fails = 0;
  int use_m = 0, sw = 24, half = 4;
  bit gen_on = 0;
  int hcnt = 0, fcnt = 0, pair_n = 0, kbit = 0;
  logic [31:0] cur = '0;
  logic [31:0] lh [0:255];
  logic [31:0] rh [0:255];
  logic sck_p = 0, ws_p = 0;

  function automatic logic [31:0] cap(input logic [31:0] w, input int s, input int l);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < l; k++) r = {r[30:0], (k < s) ? w[s-1-k] : 1'b0};
    return r;
  endfunction

  // bench clock source (slave build) and serial sender for either build
  always @(negedge clk) begin
    logic sx, wx;
    if (gen_on) begin
      hcnt++;
      if (hcnt >= half) begin
        hcnt = 0;
        if (tb_sck) begin
          fcnt++;
          if (fcnt == 32) begin fcnt = 0; tb_ws = ~tb_ws; end
        end
        tb_sck = ~tb_sck;
      end
    end
    sx = (use_m != 0) ? sck_om : tb_sck;
    wx = (use_m != 0) ? ws_om  : tb_ws;
    if (sck_p && !sx) begin
      if (wx != ws_p) begin
        ws_p = wx; kbit = 0; sd_line = 1'b0;
        if (!wx) begin
          if (pair_n < 255) pair_n++;
          lh[pair_n] = $urandom & ((32'h1 << sw) - 1);
          cur = lh[pair_n];
        end else begin
          rh[pair_n] = $urandom & ((32'h1 << sw) - 1);
          cur = rh[pair_n];
        end
      end else begin
        sd_line = (kbit < sw) ? cur[sw-1-kbit] : 1'b0;
        kbit++;
      end
    end
    sck_p = sx;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit m, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc_s = !m; cyc_m = m; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk);
    cyc_s = 0; cyc_m = 0; stb = 0; we = 0;
  endtask

  task automatic rd(input bit m, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc_s = !m; cyc_m = m; stb = 1; we = 0; adr = a;
    #1;
    d = m ? dat_m : dat_s;
    cyc_s = 0; cyc_m = 0; stb = 0;
  endtask

  task automatic wait_stat(input bit m, input int b, output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(m, 6'd3, d);
      if (d[b]) begin ok = 1; break; end
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic meas(input int dv);
    logic p;
    int c;
    p = sck_om;
    forever begin @(negedge clk); if (!p && sck_om) break; p = sck_om; end
    c = 0; p = sck_om;
    forever begin @(negedge clk); c++; if (!p && sck_om) break; p = sck_om; end
    chk("R12 sck period", c, 2 * (dv + 1));
    p = ws_om;
    forever begin @(negedge clk); if (p != ws_om) break; end
    c = 0; p = ws_om;
    forever begin @(negedge clk); c++; if (p != ws_om) break; end
    chk("R12 ws half period", c, 64 * (dv + 1));
  endtask

  task automatic run(input bit m, input int s, input int l, input int dv,
                     input bit storm, input logic [1:0] mk);
    logic [31:0] d, cfgw;
    logic [31:0] got [0:31];
    bit ok, seen;
    int n0;
    string tag;
    tag = (s < l) ? "R8/R9 zero fill" : (s > l) ? "R8/R10 truncation" : "R8 placement";
    use_m = m; sw = s;
    if (!m) half = dv + 1;
    else ws_p = 0;
    cfgw = {8'h00, 8'(l), 8'(dv), 8'h01};
    wr(m, 6'd2, {30'd0, mk});
    pair_n = 0;
    wr(m, 6'd1, cfgw);
    rd(m, 6'd1, d); chk("R3 config readback", d, cfgw);
    rd(m, 6'd2, d); chk("R3 mask readback", d, {30'd0, mk});
    if (m) meas(dv);
    wait_stat(m, 0, ok);
    chk("R4 lower half flag", ok, 1);
    chk("R7 irq on lower half", m ? irq_m : irq_s, mk[0]);
    for (int i = 0; i < 16; i++) rd(m, 6'(32 + i), got[i]);
    wr(m, 6'd3, 32'd1);
    rd(m, 6'd3, d); chk("R6 clear bit0", d & 32'd1, 0);
    if (storm) begin
      seen = 0;
      @(negedge clk);
      cyc_s = !m; cyc_m = m; stb = 1; we = 1; adr = 6'd3; wdat = 32'd2;
      repeat (6000) begin
        @(negedge clk);
        if (m ? irq_m : irq_s) seen = 1;
      end
      cyc_s = 0; cyc_m = 0; stb = 0; we = 0;
      chk("R13 set beats clear", seen, 1);
      rd(m, 6'd3, d); chk("R13 bit1 clear after writes", d & 32'd2, 0);
    end else begin
      wait_stat(m, 1, ok);
      chk("R5 upper half flag", ok, 1);
      chk("R7 irq on upper half", m ? irq_m : irq_s, mk[1]);
      wr(m, 6'd3, 32'd2);
      rd(m, 6'd3, d); chk("R6 clear bit1", d & 32'd2, 0);
      chk("R7 irq low after clear", m ? irq_m : irq_s, 0);
    end
    for (int i = 16; i < 32; i++) rd(m, 6'(32 + i), got[i]);
    wr(m, 6'd1, 32'd0);
    n0 = -1;
    for (int n = 0; n < 8; n++)
      if (n0 < 0 && cap(lh[n], s, l) == got[0] && cap(rh[n], s, l) == got[1]) n0 = n;
    chk("R11 first pair at slot 0", (n0 >= 1 && n0 <= 2), 1);
    if (n0 < 1) n0 = 1;
    for (int i = 0; i < 16; i++) begin
      chk({tag, " left"},  got[2*i],   cap(lh[n0+i], s, l));
      chk({tag, " right"}, got[2*i+1], cap(rh[n0+i], s, l));
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (4000000) begin
      @(posedge clk);
      if (vectors < 0) break;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    rst = 0;
    gen_on = 1;
    rd(0, 6'd0, d); chk("R2 slave version", d, 32'h191);
    rd(1, 6'd0, d); chk("R2 master version", d, 32'h1B1);
    for (int m = 0; m < 2; m++) begin
      rd(m[0], 6'd1, d); chk("R1 config reset", d, 0);
      rd(m[0], 6'd2, d); chk("R1 mask reset", d, 0);
      rd(m[0], 6'd3, d); chk("R1 status reset", d, 0);
    end
    chk("R1 irq reset", {irq_s, irq_m}, 0);
    chk("R1 master clocks idle", {sck_om, ws_om}, 0);
    chk("R12 slave outputs low", {sck_os, ws_os}, 0);

    run(0, 24, 24, 3, 0, 2'b11);
    run(0, 20, 24, 4, 0, 2'b11);
    run(0, 24, 16, 3, 1, 2'b10);
    run(1, 16, 16, 1, 0, 2'b01);
    for (int i = 0; i < 2; i++) begin
      int s, l, dv;
      bit m;
      s  = 16 + 4 * int'($urandom % 3);
      l  = 16 + 4 * int'($urandom % 3);
      m  = $urandom % 2;
      dv = m ? 1 + int'($urandom % 3) : 3 + int'($urandom % 3);
      run(m, s, l, dv, 0, 2'b11);
    end
    chk("R12 slave outputs low", {sck_os, ws_os}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule